// File: doc/BRIEF.md
# Signed Normalization Shift Counter

This block reports how far a signed two's-complement fixed-point sample can be shifted left before its magnitude fills the word. That distance is the number of redundant sign bits. A downstream scaler uses it to normalize the value without losing sign or precision. The sample is given on a 32-bit data input. A mode input selects one of two word sizes: a short word held in the low 16 bits, or the full 32-bit word.

Internally, a negative sample is first inverted bit by bit. The folded value then goes through a halving search for its first set bit below the sign position. The search tests a 16-bit field first, then fields of 8, 4, 2 and 1 bits, and each empty field adds its size to the count. An all-zero sample gets a count of zero in both modes. The result is captured in an output register on each valid strobe, and a valid flag follows the strobe by one clock.

Top module: `sign_norm_count`

## Requirements
- R1: While reset is asserted and on the first edge after it, `out_vld` is 0 and `out_cnt` is 0.
- R2: A sample whose selected word is all zeros yields a count of 0, in either mode.
- R3: A sample whose selected word is all ones (-1) yields 15 in short mode (`in_short`=1) and 31 in full mode (`in_short`=0).
- R4: In full mode, a non-negative sample yields the number of left shifts needed before the value is at least 0x40000000.
- R5: A negative sample is bit-inverted before it is counted, so a negative value and its bitwise complement give the same count.
- R6: In short mode, bit 15 is the sign and bits 31..16 have no effect on the result. The count is the number of left shifts needed before the folded 16-bit value is at least 0x4000.
- R7: `out_vld` is 1 exactly in the cycle after a cycle with `in_vld`=1. `out_cnt` then shows the count of the sample presented with that strobe, including back-to-back strobes.
- R8: While `in_vld` is 0, `out_cnt` keeps its last value.
- R9: The count never exceeds 15 in short mode and never exceeds 31 in full mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Sample strobe |
| in_short | input | 1 | 1 = 16-bit mode on bits 15..0, 0 = 32-bit mode |
| in_data | input | 32 | Signed sample |
| out_vld | output | 1 | Result valid, one clock after the strobe |
| out_cnt | output | 5 | Redundant sign-bit count |

## Verification
Two things can share a clock: a new sample is loaded into the output register in the same cycle that the previous result is on the output. The mode can also change between those two adjacent samples. The bench provokes this with runs of back-to-back strobes whose mode and sign are drawn at random. It judges every cycle of such a run against a reference count computed by repeated doubling. Directed cases put the 0 and -1 specials, and short-mode samples with noisy upper bits, right beside full-mode samples, so a stale mode or stale sign shows up as a wrong count.

// File: rtl/norm_pkg.sv
package norm_pkg;
   localparam int unsigned FULL_W  = 32;
   localparam int unsigned SHORT_W = 16;
   localparam int unsigned CNT_W   = $clog2(FULL_W);

   typedef enum logic {
      MODE_FULL  = 1'b0,
      MODE_SHORT = 1'b1
   } width_mode_e;
endpackage

// File: rtl/nrm_sign_fold.sv
module nrm_sign_fold #(
   parameter int unsigned FULL_W  = 32,
   parameter int unsigned SHORT_W = 16
) (
   input  logic              short_mode,
   input  logic [FULL_W-1:0] data,
   output logic [FULL_W-1:0] search_vec,
   output logic              is_zero
);
   localparam int unsigned PAD_W = FULL_W - SHORT_W;

   logic [FULL_W-1:0] full_vec;
   logic [FULL_W-1:0] short_vec;
   logic              full_zero;
   logic              short_zero;

   // Full word: drop sign, invert body when negative, append a sentinel one.
   always_comb begin
      full_vec  = {data[FULL_W-2:0] ^ {(FULL_W-1){data[FULL_W-1]}}, 1'b1};
      full_zero = (data == '0);
   end

   // Short word: left-aligned so the same search serves both widths.
   always_comb begin
      short_vec  = {data[SHORT_W-2:0] ^ {(SHORT_W-1){data[SHORT_W-1]}},
                    1'b1, {PAD_W{1'b0}}};
      short_zero = (data[SHORT_W-1:0] == '0);
   end

   assign search_vec = short_mode ? short_vec : full_vec;
   assign is_zero    = short_mode ? short_zero : full_zero;
endmodule

// File: rtl/nrm_lead_search.sv
module nrm_lead_search #(
   parameter int unsigned VEC_W = 32,
   localparam int unsigned CW   = $clog2(VEC_W)
) (
   input  logic [VEC_W-1:0] vec,
   output logic [CW-1:0]    cnt
);
   logic [VEC_W-1:0] stage [0:CW];

   assign stage[0] = vec;

   for (genvar k = 0; k < CW; k++) begin : g_step
      localparam int unsigned HALF = VEC_W >> (k + 1);
      logic upper_empty;
      assign upper_empty  = (stage[k][VEC_W-1 -: HALF] == '0);
      assign stage[k+1]   = upper_empty ? (stage[k] << HALF) : stage[k];
      assign cnt[CW-1-k]  = upper_empty;
   end
endmodule

// File: rtl/nrm_out_stage.sv
module nrm_out_stage #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] cnt_d,
   output logic             vld_q,
   output logic [CNT_W-1:0] cnt_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         vld_q <= load;
         if (load) cnt_q <= cnt_d;
      end
   end
endmodule

// File: rtl/sign_norm_count.sv
module sign_norm_count
   import norm_pkg::*;
#(
   parameter int unsigned DATA_W  = FULL_W,
   parameter int unsigned NARROW_W = SHORT_W,
   localparam int unsigned CW     = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic              in_short,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_vld,
   output logic [CW-1:0]     out_cnt
);
   if ((DATA_W & (DATA_W - 1)) != 0) begin : g_bad_w
      $error("DATA_W must be a power of two");
   end
   if (NARROW_W >= DATA_W || NARROW_W < 2) begin : g_bad_n
      $error("NARROW_W must lie between 2 and DATA_W-1");
   end

   logic [DATA_W-1:0] search_vec;
   logic              is_zero;
   logic [CW-1:0]     raw_cnt;
   logic [CW-1:0]     final_cnt;
   width_mode_e       mode;

   assign mode = width_mode_e'(in_short);

   nrm_sign_fold #(.FULL_W(DATA_W), .SHORT_W(NARROW_W)) u_fold (
      .short_mode (mode == MODE_SHORT),
      .data       (in_data),
      .search_vec (search_vec),
      .is_zero    (is_zero)
   );

   nrm_lead_search #(.VEC_W(DATA_W)) u_search (
      .vec (search_vec),
      .cnt (raw_cnt)
   );

   // Zero is the one folded value the sentinel cannot distinguish from -1.
   assign final_cnt = is_zero ? '0 : raw_cnt;

   nrm_out_stage #(.CNT_W(CW)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (in_vld),
      .cnt_d (final_cnt),
      .vld_q (out_vld),
      .cnt_q (out_cnt)
   );
endmodule

// File: rtl/sign_norm_count_chk.sv
module sign_norm_count_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CW     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_vld,
   input logic              in_short,
   input logic [DATA_W-1:0] in_data,
   input logic              out_vld,
   input logic [CW-1:0]     out_cnt
);
   AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld) else $error("valid lost");                  // R7
   AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld) else $error("spurious valid");            // R7
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(out_cnt)) else $error("count moved");       // R8
   AST_ZERO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_short && in_data[15:0] == 16'h0) |=> out_cnt == '0)
      else $error("short zero");                                      // R2
   AST_ZERO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !in_short && in_data == '0) |=> out_cnt == '0)
      else $error("full zero");                                       // R2
   AST_M1_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_short && in_data[15:0] == 16'hFFFF) |=> out_cnt == CW'(15))
      else $error("short minus one");                                 // R3
   AST_M1_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && !in_short && in_data == '1) |=> out_cnt == CW'(DATA_W-1))
      else $error("full minus one");                                  // R3
   AST_SHORT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_short) |=> out_cnt <= CW'(15))
      else $error("short range");                                     // R9
endmodule

bind sign_norm_count sign_norm_count_chk #(.DATA_W(DATA_W), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_short(in_short),
   .in_data(in_data), .out_vld(out_vld), .out_cnt(out_cnt)
);

// File: tb/sign_norm_count_bench.sv
module sign_norm_count_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic        in_short = 1'b0;
   logic [31:0] in_data = '0;
   logic        out_vld;
   logic [4:0]  out_cnt;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   sign_norm_count u_sign_norm_count (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_short(in_short),
      .in_data(in_data), .out_vld(out_vld), .out_cnt(out_cnt)
   );

   function automatic int ref_cnt(bit sh, logic [31:0] d);
      logic signed [31:0] v;
      logic signed [31:0] lim;
      int n;
      v   = sh ? {{16{d[15]}}, d[15:0]} : d;
      lim = sh ? 32'sh4000 : 32'sh40000000;
      if (v == 0) return 0;
      if (v == -1) return sh ? 15 : 31;
      if (v < 0) v = ~v;
      n = 0;
      while (v < lim) begin v = v <<< 1; n++; end
      return n;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One strobe; the result is judged at the following falling edge.
   task automatic push(string req, bit sh, logic [31:0] d);
      in_vld = 1'b1; in_short = sh; in_data = d;
      @(negedge clk);
      in_vld = 1'b0;
      check(req, int'(out_vld), 1);
      check(req, int'(out_cnt), ref_cnt(sh, d));
   endtask

   initial begin
      automatic int unsigned seed = 32'd12345;
      automatic logic [4:0] held;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      check("R1 vld", int'(out_vld), 0);
      check("R1 cnt", int'(out_cnt), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after", int'(out_vld), 0);

      push("R2 short zero", 1'b1, 32'hABCD_0000); check("R2", int'(out_cnt), 0);
      push("R2 full zero", 1'b0, 32'h0);
      push("R3 short -1", 1'b1, 32'h0000_FFFF); check("R3", int'(out_cnt), 15);
      push("R3 full -1", 1'b0, 32'hFFFF_FFFF); check("R3", int'(out_cnt), 31);
      push("R4 one", 1'b0, 32'h1); check("R4", int'(out_cnt), 30);
      push("R4 max", 1'b0, 32'h7FFF_FFFF); check("R4", int'(out_cnt), 0);
      push("R4 mid", 1'b0, 32'h0000_8000); check("R4", int'(out_cnt), 15);
      push("R5 min", 1'b0, 32'h8000_0000); check("R5", int'(out_cnt), 0);
      push("R5 neg", 1'b0, 32'hFFFF_FFFE); check("R5", int'(out_cnt), 30);
      push("R5 short neg", 1'b1, 32'h0000_FFF0); check("R5", int'(out_cnt), 11);
      push("R6 noisy top", 1'b1, 32'h1234_0001); check("R6", int'(out_cnt), 14);
      push("R6 short min", 1'b1, 32'hFFFF_8000); check("R6", int'(out_cnt), 0);
      push("R6 short 4000", 1'b1, 32'h0000_4000); check("R6", int'(out_cnt), 0);

      // R8: idle cycles leave the count in place.
      held = out_cnt;
      in_data = 32'h1; in_short = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 hold", int'(out_cnt), int'(held));
      check("R7 no strobe", int'(out_vld), 0);

      // R7/R9: random back-to-back runs with mixed mode and sign.
      for (int i = 0; i < 400; i++) begin
         automatic logic [31:0] d = $urandom;
         automatic bit sh = $urandom_range(0, 1);
         d = d >> $urandom_range(0, 31);
         if ($urandom_range(0, 1)) d = ~d;
         push("R7 random", sh, d);
         check("R9 range", int'(out_cnt <= (sh ? 5'd15 : 5'd31)), 1);
         if ($urandom_range(0, 3) == 0) begin
            held = out_cnt;
            @(negedge clk);
            check("R8 gap", int'(out_cnt), int'(held));
         end
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule